// File: doc/BRIEF.md
# Serial Configuration Memory Reader

This block models a read-only memory that boots an SRAM-based FPGA. It feeds the FPGA's configuration port over a serial link: after reset it puts out one stored bit at each rising clock edge. The storage holds 32-bit words, and a position counter walks through them in address order. There is no random access. Within a word, bit 31 goes first.

A chip-enable input starts and stops the stream. A combined reset/output-enable pin clears the position and turns off the data pad. A parameter chooses which level of that pin counts as asserted. When the last bit has gone out, the block drops its cascade-enable output. That output drives the chip-enable of a second copy, so the bits of several memories join into one long stream.

The contents are fixed when the design is elaborated. A hash of each word's address and a per-instance seed gives the word's value.

Top module: `cfgrom_serial`

## Requirements
- R1: While reset is asserted, `data_oe_o` is low and `ceo_n` is high, and the position clears. After release, the first bit presented is bit 31 of word 0.
- R2: With `RST_HIGH`=1 a high level on `rst_oe` asserts reset. With `RST_HIGH`=0 a low level asserts it, and the opposite level lets the stream run.
- R3: With `ce_n` low, reset released and the data not exhausted, `data_oe_o` is high. Each rising edge moves exactly one bit forward. A word is sent from bit 31 down to bit 0, and words follow in ascending address order.
- R4: While `ce_n` is high, `data_oe_o` is low and the position holds. When `ce_n` returns low, the stream resumes at the same bit.
- R5: Operation is static. With the clock stopped, `data_o` and `data_oe_o` hold their values, and no bit is lost when the clock restarts.
- R6: Once bit 0 of word `DEPTH`-1 has been clocked out, `ceo_n` goes low and `data_oe_o` goes low. No further bit is sent until reset.
- R7: A second device whose `ce_n` is driven by the first device's `ceo_n` presents its own word 0 bit 31 at the next bit slot. The joined stream has no gap and no repeated bit.
- R8: `ceo_n` is high whenever `ce_n` is high or reset is asserted, even after the data is exhausted.
- R9: Word i holds the value computed in four 32-bit steps: x0 = (i*0x9E3779B1) xor SEED; x1 = x0 xor (x0>>15); x2 = x1*0x85EBCA6B; word = x2 xor (x2>>13). `DEPTH` is 1134, 2048 or 4096, and one pass carries exactly `DEPTH`*32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; one bit per rising edge |
| rst_oe | input | 1 | Combined reset / output enable, active level set by `RST_HIGH` |
| ce_n | input | 1 | Chip enable, active low |
| data_o | output | 1 | Serial data bit currently presented |
| data_oe_o | output | 1 | Pad drive enable for `data_o`; low means high impedance |
| ceo_n | output | 1 | Cascade enable to the next device, active low |

## Verification
The bench goes after the seams of the stream. These are the first bit after reset release, the step from bit 0 of one word to bit 31 of the next, and the handoff from the first device to the second. A counter that steps one place too early or too late would drop or duplicate a bit at one of these points. Pausing chip-enable and stopping the clock in mid-stream expose a design that keeps counting while disabled; it would resume a few bits further on. After exhaustion the bench checks that the pad stays off and the cascade output stays low. It also checks that disabling or resetting the first device pulls the cascade output back high. A design with a sticky cascade flag would leave the second device talking. An instance with active-low reset polarity checks that the level selection is not reversed.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;

  localparam int WORD_W = 32;
  localparam int BIT_W  = $clog2(WORD_W);

  // Stored word for address idx; the bench recomputes this on its own.
  function automatic logic [WORD_W-1:0] rom_word(input logic [31:0] idx,
                                                 input logic [31:0] seed);
    logic [31:0] x;
    x = (idx * 32'h9E37_79B1) ^ seed;
    x = x ^ (x >> 15);
    x = x * 32'h85EB_CA6B;
    x = x ^ (x >> 13);
    return x;
  endfunction

  // Position within the word of the bit sent at serial step cnt (MSB first).
  function automatic logic [BIT_W-1:0] msb_pos(input logic [BIT_W-1:0] cnt);
    return BIT_W'(WORD_W - 1) - cnt;
  endfunction

endpackage

// File: rtl/cfgrom_array.sv
module cfgrom_array
  import cfgrom_pkg::*;
#(
  parameter int          DEPTH = 1134,
  parameter logic [31:0] SEED  = 32'h0,
  parameter int          AW    = $clog2(DEPTH)
) (
  input  logic [AW-1:0]     addr,
  output logic [WORD_W-1:0] word
);

  logic [WORD_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_fill
    assign rom[g] = rom_word(32'(g), SEED);
  end

  assign word = rom[addr];

endmodule

// File: rtl/cfgrom_seq.sv
module cfgrom_seq
  import cfgrom_pkg::*;
#(
  parameter int DEPTH = 1134,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_act,
  input  logic             ce_act,
  output logic [AW-1:0]    word_idx,
  output logic [BIT_W-1:0] bit_cnt,
  output logic             done
);

  localparam logic [AW-1:0]    LAST_WORD = AW'(DEPTH - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);

  logic step, at_last_bit, at_last_word, armed;

  assign step         = ce_act & ~done & ~rst_act;
  assign at_last_bit  = (bit_cnt == LAST_BIT);
  assign at_last_word = (word_idx == LAST_WORD);

  always_ff @(posedge clk) begin
    if (rst_act) begin
      word_idx <= '0;
      bit_cnt  <= '0;
      done     <= 1'b0;
    end else if (step) begin
      if (at_last_bit && at_last_word) begin
        done <= 1'b1;
      end else if (at_last_bit) begin
        bit_cnt  <= '0;
        word_idx <= word_idx + 1'b1;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_act) armed <= 1'b1;
  end

  // R3
  bit_step_chk: assert property (@(posedge clk) disable iff (rst_act || !armed)
    (step && !at_last_bit) |=> (bit_cnt == $past(bit_cnt) + 1'b1) && $stable(word_idx));

  // R3
  word_step_chk: assert property (@(posedge clk) disable iff (rst_act || !armed)
    (step && at_last_bit && !at_last_word) |=> (word_idx == $past(word_idx) + 1'b1) && (bit_cnt == '0));

  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst_act || !armed)
    !ce_act |=> $stable(word_idx) && $stable(bit_cnt));

  // R6
  exhausted_sticky_chk: assert property (@(posedge clk) disable iff (rst_act || !armed)
    done |=> done && $stable(word_idx) && $stable(bit_cnt));

endmodule

// File: rtl/cfgrom_out.sv
module cfgrom_out
  import cfgrom_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [BIT_W-1:0]  bit_cnt,
  input  logic              done,
  input  logic              rst_act,
  input  logic              ce_act,
  output logic              data_o,
  output logic              data_oe_o,
  output logic              ceo_n
);

  logic live;

  assign live      = ce_act & ~rst_act;
  assign data_o    = word[msb_pos(bit_cnt)];
  assign data_oe_o = live & ~done;
  assign ceo_n     = ~(live & done);

endmodule

// File: rtl/cfgrom_serial.sv
module cfgrom_serial
  import cfgrom_pkg::*;
#(
  parameter int          DEPTH    = 1134,
  parameter logic [31:0] SEED     = 32'h5EED_0001,
  parameter bit          RST_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_oe,
  input  logic ce_n,
  output logic data_o,
  output logic data_oe_o,
  output logic ceo_n
);

  localparam int AW = $clog2(DEPTH);

  logic              rst_act, ce_act, done;
  logic [AW-1:0]     word_idx;
  logic [BIT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] word;

  assign rst_act = (rst_oe == RST_HIGH);
  assign ce_act  = ~ce_n;

  cfgrom_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
    .clk      (clk),
    .rst_act  (rst_act),
    .ce_act   (ce_act),
    .word_idx (word_idx),
    .bit_cnt  (bit_cnt),
    .done     (done)
  );

  cfgrom_array #(.DEPTH(DEPTH), .SEED(SEED), .AW(AW)) u_array (
    .addr (word_idx),
    .word (word)
  );

  cfgrom_out u_out (
    .word      (word),
    .bit_cnt   (bit_cnt),
    .done      (done),
    .rst_act   (rst_act),
    .ce_act    (ce_act),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .ceo_n     (ceo_n)
  );

  // R6
  cascade_excl_chk: assert property (@(posedge clk) disable iff (rst_act)
    !ceo_n |-> !data_oe_o);

  // R8
  ceo_gate_chk: assert property (@(posedge clk) disable iff (rst_act)
    ce_n |-> ceo_n);

endmodule

// File: tb/sim_cfgrom_serial.sv
module sim_cfgrom_serial;

  localparam int          DEPTH = 1134;
  localparam logic [31:0] SA = 32'h1234_5678;
  localparam logic [31:0] SB = 32'hCAFE_0001;
  localparam logic [31:0] SC = 32'h0BAD_F00D;

  logic clk = 1'b0, run = 1'b1, rst = 1'b1, ce0_n = 1'b1, rstn2 = 1'b0, mon_on = 1'b0;
  wire  gclk = clk & run;
  always #4 clk = ~clk;

  logic d0, oe0, ceo0, d1, oe1, ceo1, d2, oe2, ceo2;

  cfgrom_serial #(.DEPTH(DEPTH), .SEED(SA), .RST_HIGH(1'b1)) u0 (
    .clk(gclk), .rst_oe(rst), .ce_n(ce0_n), .data_o(d0), .data_oe_o(oe0), .ceo_n(ceo0));
  cfgrom_serial #(.DEPTH(DEPTH), .SEED(SB), .RST_HIGH(1'b1)) u1 (
    .clk(gclk), .rst_oe(rst), .ce_n(ceo0), .data_o(d1), .data_oe_o(oe1), .ceo_n(ceo1));
  cfgrom_serial #(.DEPTH(DEPTH), .SEED(SC), .RST_HIGH(1'b0)) u2 (
    .clk(clk), .rst_oe(rstn2), .ce_n(1'b0), .data_o(d2), .data_oe_o(oe2), .ceo_n(ceo2));

  int checks = 0, errors = 0;
  bit exp_bit[$];
  int exp_dev[$];

  // Independent restatement of R9: four separate steps with temporaries.
  function automatic logic [31:0] ref_word(input int unsigned i, input logic [31:0] s);
    logic [31:0] p, q, r;
    p = i * 32'h9E37_79B1;
    p = p ^ s;
    q = p ^ {15'b0, p[31:15]};
    r = q * 32'h85EB_CA6B;
    return r ^ {13'b0, r[31:13]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Driver: expected stream of one device, word 0 upward, bit 31 first.
  task automatic push_device(input int dev, input logic [31:0] seed);
    for (int w = 0; w < DEPTH; w++) begin
      logic [31:0] v;
      v = ref_word(w, seed);
      for (int b = 31; b >= 0; b--) begin
        exp_bit.push_back(v[b]);
        exp_dev.push_back(dev);
      end
    end
  endtask

  // Monitor: one sample per gated clock period, after the edge has settled.
  always @(negedge gclk) begin
    if (mon_on) begin
      if (oe0 && oe1) begin
        check(1'b0, "R7 both devices driving", 32'd1, 32'd0);
      end else if (oe0 || oe1) begin
        logic act;
        act = oe0 ? d0 : d1;
        if (exp_bit.size() == 0) begin
          check(1'b0, "R6 bit after end of data", 32'(act), 32'd0);
        end else begin
          bit e;
          int dv;
          e  = exp_bit.pop_front();
          dv = exp_dev.pop_front();
          if (dv == 0) check(act == e && oe0, "R3 stream bit dev0", 32'(act), 32'(e));
          else         check(act == e && oe1, "R7 stream bit dev1", 32'(act), 32'(e));
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic d_hold, oe_hold;
    logic [31:0] w0;
    repeat (2) @(posedge clk);
    #1 ce0_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset gates the pad even with chip enable active
    check(oe0 == 1'b0, "R1 oe in reset", 32'(oe0), 32'd0);
    check(ceo0 == 1'b1, "R1 ceo in reset", 32'(ceo0), 32'd1);
    check(oe1 == 1'b0, "R1 dev1 oe in reset", 32'(oe1), 32'd0);
    // R2 active-low instance held in reset by a low level
    check(oe2 == 1'b0, "R2 low level asserts reset", 32'(oe2), 32'd0);

    push_device(0, SA);
    push_device(1, SB);
    @(posedge clk);
    #1 rst = 1'b0; mon_on = 1'b1;

    // R4 chip-enable pause mid-stream
    repeat (1000) @(posedge clk);
    #1 ce0_n = 1'b1;
    @(negedge clk);
    check(oe0 == 1'b0, "R4 oe off while disabled", 32'(oe0), 32'd0);
    check(ceo0 == 1'b1, "R8 ceo high while disabled", 32'(ceo0), 32'd1);
    repeat (20) @(posedge clk);
    #1 ce0_n = 1'b0;

    // R5 clock stopped mid-stream
    repeat (500) @(posedge clk);
    @(negedge clk);
    #1 run = 1'b0;
    d_hold = d0; oe_hold = oe0;
    repeat (10) @(posedge clk);
    check(d0 == d_hold && oe0 == oe_hold && oe0, "R5 outputs hold with clock stopped",
          {30'd0, oe0, d0}, {30'd0, 1'b1, d_hold});
    @(negedge clk);
    #1 run = 1'b1;

    // R6/R8 handoff, then disable the first device during the second's stream
    while (ceo0) @(negedge clk);
    check(oe0 == 1'b0, "R6 dev0 pad off after last bit", 32'(oe0), 32'd0);
    repeat (100) @(posedge clk);
    #1 ce0_n = 1'b1;
    @(negedge clk);
    check(ceo0 == 1'b1, "R8 ceo high when disabled after end", 32'(ceo0), 32'd1);
    check(oe1 == 1'b0, "R8 dev1 stops when ceo returns high", 32'(oe1), 32'd0);
    repeat (15) @(posedge clk);
    #1 ce0_n = 1'b0;

    while (ceo1) @(negedge clk);
    repeat (40) @(negedge clk);
    check(oe0 == 1'b0 && oe1 == 1'b0, "R6 pads stay off after end", {31'd0, oe0 | oe1}, 32'd0);
    check(ceo0 == 1'b0 && ceo1 == 1'b0, "R6 ceo stays low until reset", {30'd0, ceo0, ceo1}, 32'd0);
    check(exp_bit.size() == 0, "R9 stream length DEPTH*32 per device", 32'(exp_bit.size()), 32'd0);

    // R1 reset after exhaustion restarts at word 0 bit 31
    @(posedge clk);
    #1 rst = 1'b1; mon_on = 1'b0;
    @(negedge clk);
    check(ceo0 == 1'b1 && ceo1 == 1'b1, "R1 reset raises ceo", {30'd0, ceo0, ceo1}, 32'd3);
    check(oe0 == 1'b0, "R1 reset turns pad off", 32'(oe0), 32'd0);
    @(posedge clk);
    #1 rst = 1'b0;
    w0 = ref_word(0, SA);
    @(negedge clk);
    check(oe0 && d0 == w0[31], "R1 first bit after reset", {30'd0, oe0, d0}, {30'd0, 1'b1, w0[31]});
    @(negedge clk);
    check(d0 == w0[30], "R3 second bit is bit 30", 32'(d0), 32'(w0[30]));

    // R2 active-low polarity instance
    @(posedge clk);
    #1 rstn2 = 1'b1;
    for (int k = 0; k < 64; k++) begin
      logic [31:0] v;
      v = ref_word(k / 32, SC);
      @(negedge clk);
      check(oe2 && d2 == v[31 - (k % 32)], "R2 high level lets stream run",
            {30'd0, oe2, d2}, {30'd0, 1'b1, v[31 - (k % 32)]});
    end
    @(posedge clk);
    #1 rstn2 = 1'b0;
    @(negedge clk);
    check(oe2 == 1'b0 && ceo2 == 1'b1, "R2 low level asserts reset", {30'd0, oe2, ceo2}, 32'd1);
    @(posedge clk);
    #1 rstn2 = 1'b1;
    w0 = ref_word(0, SC);
    @(negedge clk);
    check(oe2 && d2 == w0[31], "R2 restart at word 0 bit 31", {30'd0, oe2, d2}, {30'd0, 1'b1, w0[31]});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule